// File: doc/BRIEF.md
# Indexed-Colour Display Register Bank

This block is the control slave of an indexed-colour display controller. A host writes and reads 32-bit words through a simple valid/write strobe interface. Word addresses are byte offsets on an 8-byte grid inside a 1.5 MiB window. Behind that window sit a 256-entry colour lookup table and a 512-word cursor bitmap, both held in inferred block RAM. A three-entry cursor colour set, a control word, a cursor position and a screen start offset are held in flops.

The scan-out stage reads the lookup table and the cursor bitmap through their own registered read ports. It gets the cursor colours, position, start offset, blanking and cursor-hide flags as steady outputs, together with the decoded pixel depth.

The block owns the frame interrupt. A frame-end pulse from the video timing logic sets it, and any host write clears it. Writes to the CRT timing registers are taken without effect, since video timing lives elsewhere. Anything else outside the map is reported on a one-cycle error flag.

Top module: `dispctl_regs`

## Requirements
- R1: Each access with `bus_valid` high is one 32-bit word at byte address `bus_addr`. A read returns its data on `bus_rdata` in the following cycle, with `bus_rvalid` high for exactly that one cycle. Writes never raise `bus_rvalid`.
- R2: Colour table entry i (0..255) is at 0x800 + 8*i. Write data carries red in bits [23:16], green in [15:8] and blue in [7:0]. A read returns those 24 bits with bits [31:24] zero. The scan port returns entry `pal_raddr` on `pal_rdata` one cycle after the address is presented.
- R3: Cursor bitmap word i (0..511) is at 0x1000 + 8*i. It stores write data bits [15:0] and reads back with bits [31:16] zero. The scan port returns word `pat_raddr` on `pat_rdata` one cycle later.
- R4: Cursor colours k = 0, 1, 2 are at 0x508, 0x510 and 0x518. They use the same red/green/blue packing as R2, read back in that packing, and drive `cur_pal` bits [24k+23:24k].
- R5: The control word at 0x300, the cursor position at 0x638 and the screen start offset at 0x400 each store all 32 bits. Each reads back unchanged and drives `ctrl_word`, `cursor_pos` and `top_offset` respectively.
- R6: Control bits [22:20] select the pixel depth. Codes 0 to 5 give `pix_depth` = 1, 2, 4, 8, 15 and 16 with `depth_ok` = 1. Codes 6 and 7 give `pix_depth` = 0 and `depth_ok` = 0.
- R7: Control bit 10 drives `force_blank` and control bit 23 drives `cursor_off`.
- R8: Writes to the timing addresses are accepted with `bus_err` low and change no output or readable register. The timing addresses are 0x000, 0x108 through 0x148 in steps of 8, 0x158, 0x160, 0x168, 0x170 and 0x200. Reads of these addresses return zero with `bus_err` high.
- R9: An address with bits [2:0] non-zero, at or above 0x180000, or matching none of R2 to R8 is unmapped. A write there changes nothing, and a read there returns zero. In both cases `bus_err` is high for one cycle, in the cycle after the access.
- R10: A `frame_end` pulse sets `frame_irq` in the next cycle. Any write access, mapped or not, clears it in the next cycle. When both happen in the same cycle, `frame_irq` is set.
- R11: Reset (`rst` high at a clock edge) returns both tables, the cursor colours, control word, cursor position and start offset to zero, and lowers `frame_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Access error pulse |
| frame_end | input | 1 | End-of-frame pulse from timing logic |
| frame_irq | output | 1 | Frame interrupt |
| pal_raddr | input | 8 | Colour table scan address |
| pal_rdata | output | 24 | Colour table scan data |
| pat_raddr | input | 9 | Cursor bitmap scan address |
| pat_rdata | output | 16 | Cursor bitmap scan data |
| cur_pal | output | 72 | Cursor colours, entry k at [24k+23:24k] |
| ctrl_word | output | 32 | Control word |
| cursor_pos | output | 32 | Cursor position |
| top_offset | output | 32 | Screen start offset |
| pix_depth | output | 5 | Decoded bits per pixel, 0 if unsupported |
| depth_ok | output | 1 | Depth code supported |
| force_blank | output | 1 | Blank the display |
| cursor_off | output | 1 | Hide the cursor |

## Verification
The bench targets the table boundaries: the first and last colour entries, the last bitmap word, and the word just past the cursor colours. An off-by-one decode there would alias or flag a valid entry. A misaligned write next to a live table entry checks that the low address bits are not dropped; a design that dropped them would overwrite the entry. Writes to timing addresses must leave the control word alone and raise no error, while reads there must flag one. Interrupt priority is checked by a write landing in the same cycle as a frame-end pulse; a design that let the clear win would lose the interrupt. A reset after filling every structure must read back zeros from both RAM tables, which catches a design that only clears its flops.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int RGB_W = 24;

  localparam logic [31:0] WINDOW     = 32'h0018_0000;
  localparam logic [31:0] PAL_BASE   = 32'h0000_0800;
  localparam logic [31:0] PAT_BASE   = 32'h0000_1000;
  localparam logic [31:0] CPAL_BASE  = 32'h0000_0508;
  localparam logic [31:0] CTRL_ADDR  = 32'h0000_0300;
  localparam logic [31:0] TOP_ADDR   = 32'h0000_0400;
  localparam logic [31:0] CPOS_ADDR  = 32'h0000_0638;
  localparam logic [31:0] TIM_LO     = 32'h0000_0108;
  localparam logic [31:0] TIM_HI     = 32'h0000_0148;

  localparam int DEPTH_LSB  = 20;
  localparam int BLANK_BIT  = 10;
  localparam int CUROFF_BIT = 23;

  typedef enum logic [3:0] {
    RG_NONE, RG_PAL, RG_PAT, RG_CPAL, RG_CTRL, RG_CPOS, RG_TOP, RG_TIMING
  } dcr_region_e;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAL_DEPTH = 256,
  parameter int PAT_DEPTH = 512,
  parameter int CPAL_N    = 3,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int PAT_AW   = $clog2(PAT_DEPTH),
  localparam int CPAL_AW  = $clog2(CPAL_N)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output dcr_region_e        region_o,
  output logic [PAL_AW-1:0]  pal_idx_o,
  output logic [PAT_AW-1:0]  pat_idx_o,
  output logic [CPAL_AW-1:0] cpal_idx_o
);

  localparam logic [31:0] PAL_END  = PAL_BASE  + 32'(PAL_DEPTH * 8);
  localparam logic [31:0] PAT_END  = PAT_BASE  + 32'(PAT_DEPTH * 8);
  localparam logic [31:0] CPAL_END = CPAL_BASE + 32'(CPAL_N * 8);

  logic [31:0] a;
  logic [31:0] pal_off, pat_off, cpal_off;
  logic        timing_hit;

  always_comb begin
    a        = 32'(addr_i);
    pal_off  = (a - PAL_BASE)  >> 3;
    pat_off  = (a - PAT_BASE)  >> 3;
    cpal_off = (a - CPAL_BASE) >> 3;
    pal_idx_o  = pal_off[PAL_AW-1:0];
    pat_idx_o  = pat_off[PAT_AW-1:0];
    cpal_idx_o = cpal_off[CPAL_AW-1:0];

    timing_hit = (a >= TIM_LO && a <= TIM_HI) || (a == 32'h000) ||
                 (a == 32'h158) || (a == 32'h160) || (a == 32'h168) ||
                 (a == 32'h170) || (a == 32'h200);

    if (a[2:0] != 3'b000 || a >= WINDOW)          region_o = RG_NONE;
    else if (a >= PAL_BASE  && a < PAL_END)       region_o = RG_PAL;
    else if (a >= PAT_BASE  && a < PAT_END)       region_o = RG_PAT;
    else if (a >= CPAL_BASE && a < CPAL_END)      region_o = RG_CPAL;
    else if (a == CTRL_ADDR)                      region_o = RG_CTRL;
    else if (a == CPOS_ADDR)                      region_o = RG_CPOS;
    else if (a == TOP_ADDR)                       region_o = RG_TOP;
    else if (timing_hit)                          region_o = RG_TIMING;
    else                                          region_o = RG_NONE;
  end

endmodule

// File: rtl/dcr_dp_ram.sv
module dcr_dp_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [WIDTH-1:0] qa, qb;
  logic             va, vb;

  // storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[ra_addr];
    qb <= mem[rb_addr];
  end

  // written-since-reset flags give a one-cycle logical clear
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      va  <= 1'b0;
      vb  <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      va <= vld[ra_addr];
      vb <= vld[rb_addr];
    end
  end

  assign ra_data = va ? qa : '0;
  assign rb_data = vb ? qb : '0;

  // R11
  ram_reset_zero_chk: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0));

endmodule

// File: rtl/dcr_irq.sv
module dcr_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o);
  // R10
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(irq_o));
  // R11
  irq_reset_chk: assert property (@(posedge clk) rst |=> !irq_o);

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dcr_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAL_DEPTH = 256,
  parameter int PAT_DEPTH = 512,
  parameter int PAT_W     = 16,
  parameter int CPAL_N    = 3,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int PAT_AW   = $clog2(PAT_DEPTH),
  localparam int CPAL_AW  = $clog2(CPAL_N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  output logic                    bus_err,
  input  logic                    frame_end,
  output logic                    frame_irq,
  input  logic [PAL_AW-1:0]       pal_raddr,
  output logic [RGB_W-1:0]        pal_rdata,
  input  logic [PAT_AW-1:0]       pat_raddr,
  output logic [PAT_W-1:0]        pat_rdata,
  output logic [CPAL_N*RGB_W-1:0] cur_pal,
  output logic [31:0]             ctrl_word,
  output logic [31:0]             cursor_pos,
  output logic [31:0]             top_offset,
  output logic [4:0]              pix_depth,
  output logic                    depth_ok,
  output logic                    force_blank,
  output logic                    cursor_off
);

  dcr_region_e        region, rkind_q;
  logic [PAL_AW-1:0]  pal_idx;
  logic [PAT_AW-1:0]  pat_idx;
  logic [CPAL_AW-1:0] cpal_idx;
  logic               wr, rd;
  logic [RGB_W-1:0]   pal_bus_q;
  logic [PAT_W-1:0]   pat_bus_q;
  logic [RGB_W-1:0]   cpal_q [CPAL_N];
  logic [31:0]        scalar_q, scalar_d;

  assign wr = bus_valid &  bus_write;
  assign rd = bus_valid & ~bus_write;

  dcr_decode #(
    .ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH), .PAT_DEPTH(PAT_DEPTH), .CPAL_N(CPAL_N)
  ) u_dec (
    .addr_i(bus_addr), .region_o(region),
    .pal_idx_o(pal_idx), .pat_idx_o(pat_idx), .cpal_idx_o(cpal_idx)
  );

  dcr_dp_ram #(.DEPTH(PAL_DEPTH), .WIDTH(RGB_W)) u_pal (
    .clk(clk), .rst(rst),
    .we(wr && region == RG_PAL), .waddr(pal_idx), .wdata(bus_wdata[RGB_W-1:0]),
    .ra_addr(pal_idx), .ra_data(pal_bus_q),
    .rb_addr(pal_raddr), .rb_data(pal_rdata)
  );

  dcr_dp_ram #(.DEPTH(PAT_DEPTH), .WIDTH(PAT_W)) u_pat (
    .clk(clk), .rst(rst),
    .we(wr && region == RG_PAT), .waddr(pat_idx), .wdata(bus_wdata[PAT_W-1:0]),
    .ra_addr(pat_idx), .ra_data(pat_bus_q),
    .rb_addr(pat_raddr), .rb_data(pat_rdata)
  );

  dcr_irq u_irq (
    .clk(clk), .rst(rst), .set_i(frame_end), .clr_i(wr), .irq_o(frame_irq)
  );

  // cursor colour set
  for (genvar k = 0; k < CPAL_N; k++) begin : g_cpal
    always_ff @(posedge clk) begin
      if (rst) cpal_q[k] <= '0;
      else if (wr && region == RG_CPAL && cpal_idx == CPAL_AW'(k))
        cpal_q[k] <= bus_wdata[RGB_W-1:0];
    end
    assign cur_pal[k*RGB_W +: RGB_W] = cpal_q[k];
  end

  // scalar registers and decoded control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_word   <= '0;
      cursor_pos  <= '0;
      top_offset  <= '0;
      pix_depth   <= depth_of(3'd0);
      depth_ok    <= 1'b1;
      force_blank <= 1'b0;
      cursor_off  <= 1'b0;
    end else if (wr) begin
      case (region)
        RG_CTRL: begin
          ctrl_word   <= bus_wdata;
          pix_depth   <= depth_of(bus_wdata[DEPTH_LSB +: 3]);
          depth_ok    <= (bus_wdata[DEPTH_LSB +: 3] < 3'd6);
          force_blank <= bus_wdata[BLANK_BIT];
          cursor_off  <= bus_wdata[CUROFF_BIT];
        end
        RG_CPOS: cursor_pos <= bus_wdata;
        RG_TOP:  top_offset <= bus_wdata;
        default: ;
      endcase
    end
  end

  // read path: one register stage for every source
  always_comb begin
    scalar_d = '0;
    case (region)
      RG_CTRL: scalar_d = ctrl_word;
      RG_CPOS: scalar_d = cursor_pos;
      RG_TOP:  scalar_d = top_offset;
      RG_CPAL:
        for (int k = 0; k < CPAL_N; k++)
          if (cpal_idx == CPAL_AW'(k)) scalar_d = 32'(cpal_q[k]);
      default: scalar_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      rkind_q    <= RG_NONE;
      scalar_q   <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_err    <= bus_valid && (region == RG_NONE || (rd && region == RG_TIMING));
      rkind_q    <= region;
      scalar_q   <= scalar_d;
    end
  end

  always_comb begin
    case (rkind_q)
      RG_PAL:  bus_rdata = 32'(pal_bus_q);
      RG_PAT:  bus_rdata = 32'(pat_bus_q);
      default: bus_rdata = scalar_q;
    endcase
  end

  // R1
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid);
  // R9
  err_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && bus_err) |-> bus_rdata == 32'd0);
  // R6
  depth_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && region == RG_CTRL) |=>
      (pix_depth == depth_of($past(bus_wdata[DEPTH_LSB +: 3]))));
  // R8
  timing_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && region == RG_TIMING) |=> (!bus_err && $stable(ctrl_word)));

endmodule

// File: tb/dispctl_regs_test.sv
`timescale 1ns/1ps
module dispctl_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic        frame_end = 1'b0;
  logic        frame_irq;
  logic [7:0]  pal_raddr = '0;
  logic [23:0] pal_rdata;
  logic [8:0]  pat_raddr = '0;
  logic [15:0] pat_rdata;
  logic [71:0] cur_pal;
  logic [31:0] ctrl_word, cursor_pos, top_offset;
  logic [4:0]  pix_depth;
  logic        depth_ok, force_blank, cursor_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [31:0] data; logic err; string tag; } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  dispctl_regs uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .frame_end(frame_end),
    .frame_irq(frame_irq), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
    .pat_raddr(pat_raddr), .pat_rdata(pat_rdata), .cur_pal(cur_pal),
    .ctrl_word(ctrl_word), .cursor_pos(cursor_pos), .top_offset(top_offset),
    .pix_depth(pix_depth), .depth_ok(depth_ok), .force_blank(force_blank),
    .cursor_off(cursor_off)
  );

  task automatic cmp(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected rvalid actual=1 expected=0");
      end else begin
        exp_t e;
        e = expq.pop_front();
        cmp(bus_rdata, e.data, {e.tag, " rdata"});
        cmp(32'(bus_err), 32'(e.err), {e.tag, " err"});
      end
    end
  end

  task automatic rd(input logic [20:0] a, input logic [31:0] exp, input logic err,
                    input string tag);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    e.data = exp; e.err = err; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d, input logic err,
                    input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    cmp(32'(bus_err), 32'(err), {tag, " write err"});
  endtask

  function automatic logic [4:0] exp_depth(input int c);
    case (c)
      0: return 5'd1;  1: return 5'd2;  2: return 5'd4;
      3: return 5'd8;  4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    cmp(32'(frame_irq), 0, "R11 irq after reset");
    cmp(ctrl_word, 0, "R11 ctrl after reset");
    rd(21'h800, 0, 0, "R11 palette after reset");
    rd(21'h1000, 0, 0, "R11 bitmap after reset");

    // R2 colour table, first and last entries, scan port
    wr(21'h800, 32'hAB12_3456, 0, "R2");
    wr(21'hFF8, 32'h00FE_DCBA, 0, "R2");
    rd(21'h800, 32'h0012_3456, 0, "R2 first entry");
    rd(21'hFF8, 32'h00FE_DCBA, 0, "R2 last entry");
    @(negedge clk); pal_raddr = 8'd255;
    @(negedge clk); cmp(32'(pal_rdata), 32'hFE_DCBA, "R2 scan port");

    // R3 cursor bitmap
    wr(21'h1000, 32'hFFFF_BEEF, 0, "R3");
    wr(21'h1FF8, 32'h0000_1234, 0, "R3");
    rd(21'h1000, 32'h0000_BEEF, 0, "R3 first word");
    rd(21'h1FF8, 32'h0000_1234, 0, "R3 last word");
    @(negedge clk); pat_raddr = 9'd511;
    @(negedge clk); cmp(32'(pat_rdata), 32'h1234, "R3 scan port");

    // R4 cursor colours and the address just past them
    wr(21'h508, 32'h0011_2233, 0, "R4");
    wr(21'h510, 32'hFFA1_B2C3, 0, "R4");
    wr(21'h518, 32'h0044_5566, 0, "R4");
    rd(21'h510, 32'h00A1_B2C3, 0, "R4 readback");
    cmp(32'(cur_pal[47:24]), 32'hA1B2C3, "R4 cur_pal entry1");
    cmp(32'(cur_pal[71:48]), 32'h445566, "R4 cur_pal entry2");
    wr(21'h520, 32'h1, 1, "R9 past cursor colours");

    // R5 scalar registers
    wr(21'h638, 32'h0123_4567, 0, "R5");
    wr(21'h400, 32'h89AB_CDEF, 0, "R5");
    rd(21'h638, 32'h0123_4567, 0, "R5 cursor pos");
    rd(21'h400, 32'h89AB_CDEF, 0, "R5 top offset");
    cmp(cursor_pos, 32'h0123_4567, "R5 cursor_pos port");
    cmp(top_offset, 32'h89AB_CDEF, "R5 top_offset port");

    // R6 every depth code
    for (int c = 0; c < 8; c++) begin
      wr(21'h300, 32'(c) << 20, 0, "R6");
      cmp(32'(pix_depth), 32'(exp_depth(c)), "R6 depth");
      cmp(32'(depth_ok), 32'(c < 6), "R6 depth_ok");
    end

    // R7 blank and cursor-hide bits
    wr(21'h300, 32'h0080_0400 | (32'd3 << 20), 0, "R7");
    cmp(32'(force_blank), 1, "R7 force_blank");
    cmp(32'(cursor_off), 1, "R7 cursor_off");
    rd(21'h300, 32'h00B0_0400, 0, "R5 ctrl readback");

    // R8 timing registers
    wr(21'h130, 32'hFFFF_FFFF, 0, "R8");
    wr(21'h000, 32'hFFFF_FFFF, 0, "R8");
    wr(21'h200, 32'hFFFF_FFFF, 0, "R8");
    cmp(ctrl_word, 32'h00B0_0400, "R8 ctrl unchanged");
    rd(21'h130, 0, 1, "R8 timing read");

    // R9 unmapped
    wr(21'h804, 32'h00FF_FFFF, 1, "R9 misaligned");
    rd(21'h800, 32'h0012_3456, 0, "R9 entry untouched");
    rd(21'h18_0000, 0, 1, "R9 outside window");
    rd(21'h150, 0, 1, "R9 gap read");

    // R10 interrupt
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    cmp(32'(frame_irq), 1, "R10 set");
    wr(21'h7FF8, 32'h0, 1, "R10 unmapped write");
    cmp(32'(frame_irq), 0, "R10 cleared by any write");
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 21'h130; frame_end = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; frame_end = 1'b0;
    cmp(32'(frame_irq), 1, "R10 frame end wins");

    // R11 reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cmp(32'(frame_irq), 0, "R11 irq");
    cmp(cursor_pos | top_offset | ctrl_word, 0, "R11 scalars");
    cmp(32'(cur_pal != 0), 0, "R11 cursor colours");
    rd(21'hFF8, 0, 0, "R11 colour table");
    rd(21'h1000, 0, 0, "R11 bitmap");
    @(negedge clk); pal_raddr = 8'd0;
    @(negedge clk); cmp(32'(pal_rdata), 0, "R11 palette scan");

    repeat (3) @(negedge clk);
    if (expq.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 missing reads actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule